// File: doc/BRIEF.md
# Readback Word FIFO with All-or-Nothing Packet Entry

This block buffers configuration readback data on its way from the configuration rows to a processor bus. A producer offers packets of four 32-bit words with a single strobe. The block takes the whole packet when at least four words of space are free; otherwise it discards the whole packet and raises a sticky overflow flag. It never pushes back on the producer. An accepted packet goes into a one-packet staging buffer. From there its words move into a single-port word memory, one word per cycle, word 0 first.

The bus side drains the memory one word per read request. Each request gets a response one cycle later. A request to an empty FIFO returns zero and changes nothing. Bus writes to the port are not supported: the block ignores them and answers each with an error pulse. A word read has priority over a staging write for the single memory port, so a read delays the staging buffer by one cycle. The default depth is 2048 words.

Top module: `readback_fifo`

## Requirements
- R1: After reset the FIFO holds no words, `pkt_busy` and `ovf_flag` are 0, and `rd_valid` is 0 while no read is requested.
- R2: A packet offered while `pkt_busy` is 0 is accepted when DEPTH minus the stored-plus-staged word count is at least PKT. Its words leave the FIFO in order, word 0 first, where word i sits at bits [32*i+31:32*i] of `pkt_words`.
- R3: A packet offered when fewer than PKT words are free is discarded entirely, none of its words is ever read out, and `ovf_flag` reads 1 from the next cycle.
- R4: A packet offered while `pkt_busy` is 1 is discarded entirely and sets `ovf_flag`.
- R5: A read of an empty FIFO responds with `rd_data` equal to 0 and removes nothing.
- R6: A read of a non-empty FIFO returns the oldest stored word and removes it, in first-in first-out order across packets.
- R7: When a packet and a read arrive in the same cycle, the space check uses the word count from before that read.
- R8: `ovf_flag` stays 1 until a cycle with `ovf_clr` high and no discard. A discard in the same cycle as `ovf_clr` leaves the flag at 1.
- R9: A pulse on `bus_wr` produces a one-cycle pulse on `wr_err` in the next cycle and does not change the stored contents.
- R10: After acceptance `pkt_busy` stays 1 for exactly PKT cycles plus one cycle for every read that removes a word during that time.
- R11: Every read request is answered with `rd_valid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet strobe from the producer |
| pkt_words | input | PKT*DW | Packet payload, word 0 in the low bits |
| pkt_busy | output | 1 | Staging buffer still moving words into memory |
| rd_req | input | 1 | Bus read request, one word |
| rd_valid | output | 1 | Read response valid, one cycle after the request |
| rd_data | output | DW | Read response word (0 when the FIFO was empty) |
| bus_wr | input | 1 | Bus write attempt to the port |
| wr_err | output | 1 | Error pulse answering a bus write |
| ovf_flag | output | 1 | Sticky flag for a discarded packet |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |

## Verification
A bench model queue is compared with the design at a depth of 16. The bench sweeps the fill level before a packet from full down to four words free. This separates a correct space check from an off-by-one in either direction. Packets offered while the staging buffer is busy, and packets offered in the same cycle as a read at free counts of three and four, show whether the check uses the level before the pop. Reads during staging, empty reads and a bus write placed between stored packets show whether a read steals a memory cycle as intended. They also show that nothing is removed or changed by mistake.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  // True when a packet of `need` words still fits next to `level` words.
  function automatic logic has_room(input int unsigned level,
                                    input int unsigned depth,
                                    input int unsigned need);
    return (level + need) <= depth;
  endfunction

  // Words still waiting in the staging buffer.
  function automatic int unsigned pend_words(input logic busy,
                                             input int unsigned idx,
                                             input int unsigned pkt);
    return busy ? (pkt - idx) : 0;
  endfunction

endpackage

// File: rtl/rbf_spram.sv
module rbf_spram #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else if (re) rdata_q <= mem[addr];
  end

  assign rdata = rdata_q;

  // one access per cycle on the single port
  p_single_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

// File: rtl/rbf_pkt_stage.sv
module rbf_pkt_stage #(
  parameter int DW  = 32,
  parameter int PKT = 4,
  localparam int IW = (PKT > 1) ? $clog2(PKT) : 1,
  localparam int PW = $clog2(PKT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PKT*DW-1:0] load_words,
  input  logic            advance,
  output logic            busy,
  output logic [DW-1:0]   word,
  output logic [PW-1:0]   pending
);

  logic [DW-1:0] slot_q [PKT];
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic          last_w;

  for (genvar g = 0; g < PKT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (load) slot_q[g] <= load_words[g*DW +: DW];
    end
  end

  assign last_w = (idx_q == IW'(PKT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q && advance) begin
      busy_q <= !last_w;
      idx_q  <= last_w ? '0 : idx_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign word    = slot_q[idx_q];
  assign pending = PW'(rbf_pkg::pend_words(busy_q, 32'(idx_q), PKT));

  // a new packet is only loaded into an idle stage
  p_load_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
  // a stalled stage keeps its position
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !advance && !load) |=> (busy_q && $stable(idx_q)));

endmodule

// File: rtl/readback_fifo.sv
module readback_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 2048,
  parameter int PKT   = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = $clog2(PKT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pkt_valid,
  input  logic [PKT*DW-1:0] pkt_words,
  output logic            pkt_busy,
  input  logic            rd_req,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  input  logic            bus_wr,
  output logic            wr_err,
  output logic            ovf_flag,
  input  logic            ovf_clr
);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [CW-1:0] stored_q;
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW:0]   level_w;
  logic [PW-1:0] stage_pending;
  logic          stage_busy;
  logic [DW-1:0] stage_word;
  logic          fifo_empty, pop_go, wr_go, pkt_accept, pkt_drop;
  logic          rd_valid_q, rd_zero_q, ovf_q, wr_err_q;
  logic [DW-1:0] ram_q;

  assign level_w    = {1'b0, stored_q} + (CW+1)'(stage_pending);
  assign fifo_empty = (stored_q == '0);
  assign pop_go     = rd_req && !fifo_empty;
  assign wr_go      = stage_busy && !pop_go;
  assign pkt_accept = pkt_valid && !stage_busy &&
                      rbf_pkg::has_room(32'(level_w), DEPTH, PKT);
  assign pkt_drop   = pkt_valid && !pkt_accept;

  rbf_pkt_stage #(.DW(DW), .PKT(PKT)) i_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (pkt_accept),
    .load_words (pkt_words),
    .advance    (wr_go),
    .busy       (stage_busy),
    .word       (stage_word),
    .pending    (stage_pending)
  );

  rbf_spram #(.DW(DW), .DEPTH(DEPTH)) i_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .re    (pop_go),
    .addr  (pop_go ? rd_ptr_q : wr_ptr_q),
    .wdata (stage_word),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_go) begin
        wr_ptr_q <= next_ptr(wr_ptr_q);
        stored_q <= stored_q + 1'b1;
      end else if (pop_go) begin
        rd_ptr_q <= next_ptr(rd_ptr_q);
        stored_q <= stored_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_zero_q  <= 1'b0;
      ovf_q      <= 1'b0;
      wr_err_q   <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      rd_zero_q  <= rd_req && fifo_empty;
      wr_err_q   <= bus_wr;
      if (pkt_drop) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign pkt_busy = stage_busy;
  assign rd_valid = rd_valid_q;
  assign rd_data  = (rd_valid_q && !rd_zero_q) ? ram_q : '0;
  assign wr_err   = wr_err_q;
  assign ovf_flag = ovf_q;

  p_level_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_w <= (CW+1)'(DEPTH));
  p_drop_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |=> ovf_flag);
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  p_rd_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fifo_empty) |=> (rd_data == '0));
  p_empty_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && fifo_empty && !stage_busy) |=> $stable(stored_q));
  p_wr_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> wr_err);

endmodule

// File: tb/test_readback_fifo.sv
`timescale 1ns/1ps
module test_readback_fifo;
  localparam int TDEPTH = 16;
  localparam int TPKT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_valid = 1'b0;
  logic [TPKT*32-1:0] pkt_words = '0;
  logic pkt_busy, rd_valid, wr_err, ovf_flag;
  logic rd_req = 1'b0, bus_wr = 1'b0, ovf_clr = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mq [$];

  always #2 clk = ~clk;

  readback_fifo #(.DW(32), .DEPTH(TDEPTH), .PKT(TPKT)) i_readback_fifo (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_words(pkt_words),
    .pkt_busy(pkt_busy), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .bus_wr(bus_wr), .wr_err(wr_err),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr));

  function automatic logic [31:0] wv(input int k, input int i);
    return {16'hBEEF, 12'(k), 4'(i)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_pkt(input int k);
    for (int i = 0; i < TPKT; i++) pkt_words[i*32 +: 32] = wv(k, i);
  endtask

  // offer a packet; model decides acceptance from its own occupancy
  task automatic push(input int k, output bit acc);
    load_pkt(k);
    acc = !pkt_busy && (TDEPTH - mq.size() >= TPKT);
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    if (acc) for (int i = 0; i < TPKT; i++) mq.push_back(wv(k, i));
  endtask

  task automatic rd(input string req);
    logic [31:0] exp;
    exp = (mq.size() > 0) ? mq.pop_front() : 32'h0;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check("R11 rd_valid", {31'b0, rd_valid}, 32'd1);
    check(req, rd_data, exp);
  endtask

  task automatic wait_idle();
    while (pkt_busy) @(negedge clk);
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  task automatic drain(input string req);
    while (mq.size() > 0) rd(req);
  endtask

  task automatic fill_full(input int base);
    bit a;
    for (int n = 0; n < TDEPTH / TPKT; n++) begin
      push(base + n, a);
      wait_idle();
    end
  endtask

  initial begin
    bit acc;
    int cnt;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'b0, pkt_busy}, 32'd0);
    check("R1 ovf", {31'b0, ovf_flag}, 32'd0);
    check("R1 rd_valid idle", {31'b0, rd_valid}, 32'd0);
    rd("R5 empty read after reset");
    check("R1 ovf after empty read", {31'b0, ovf_flag}, 32'd0);

    // R2 / R6 order within and across packets
    push(1, acc); check("R2 accept", {31'b0, acc}, 32'd1); wait_idle();
    push(2, acc); wait_idle();
    drain("R6 fifo order");
    rd("R5 empty after drain");

    // R10 busy length, plain and with a stealing read
    push(10, acc);
    cnt = 0;
    while (pkt_busy) begin cnt++; @(negedge clk); end
    check("R10 busy plain", cnt, TPKT);
    push(11, acc);
    cnt = 1;
    exp = mq.pop_front();
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check("R10 read during staging", rd_data, exp);
    while (pkt_busy) begin cnt++; @(negedge clk); end
    check("R10 busy with read", cnt, TPKT + 1);
    drain("R6 after staged read");

    // R4 packet while busy
    push(20, acc);
    push(21, acc);
    check("R4 model drop", {31'b0, acc}, 32'd0);
    check("R4 ovf set", {31'b0, ovf_flag}, 32'd1);
    wait_idle(); clear_ovf();
    drain("R4 dropped packet absent");
    rd("R4 nothing extra");

    // R3 sweep of free space from 0 to 4
    for (int p = 0; p <= TPKT; p++) begin
      fill_full(30 + p * 8);
      for (int j = 0; j < p; j++) rd("R6 pre-pop");
      clear_ovf();
      push(100 + p, acc);
      check("R3 accept rule", {31'b0, acc}, {31'b0, (p >= TPKT)});
      check("R3 ovf on drop", {31'b0, ovf_flag}, {31'b0, !acc});
      wait_idle();
      drain("R3 contents");
      rd("R5 empty after sweep");
    end

    // R7 same-cycle push and pop
    clear_ovf();
    fill_full(60);
    for (int j = 0; j < 3; j++) rd("R6 pre-pop");
    load_pkt(70);
    acc = (TDEPTH - mq.size() >= TPKT);
    exp = mq.pop_front();
    pkt_valid = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0; rd_req = 1'b0;
    check("R7 model drop at free 3", {31'b0, acc}, 32'd0);
    check("R7 read data", rd_data, exp);
    check("R7 ovf set", {31'b0, ovf_flag}, 32'd1);
    clear_ovf();
    load_pkt(71);
    acc = (TDEPTH - mq.size() >= TPKT);
    exp = mq.pop_front();
    pkt_valid = 1'b1; rd_req = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0; rd_req = 1'b0;
    if (acc) for (int i = 0; i < TPKT; i++) mq.push_back(wv(71, i));
    check("R7 accept at free 4", {31'b0, acc}, 32'd1);
    check("R7 read data 2", rd_data, exp);
    check("R7 no ovf", {31'b0, ovf_flag}, 32'd0);
    wait_idle();
    drain("R7 contents");

    // R8 sticky flag and clear priority
    push(80, acc); push(81, acc);
    repeat (3) @(negedge clk);
    check("R8 sticky", {31'b0, ovf_flag}, 32'd1);
    clear_ovf();
    check("R8 cleared", {31'b0, ovf_flag}, 32'd0);
    wait_idle();
    push(82, acc);
    load_pkt(83);
    pkt_valid = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0; ovf_clr = 1'b0;
    check("R8 set beats clear", {31'b0, ovf_flag}, 32'd1);
    wait_idle(); clear_ovf();
    drain("R8 contents");

    // R9 bus write ignored
    push(90, acc); wait_idle();
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 err pulse", {31'b0, wr_err}, 32'd1);
    @(negedge clk);
    check("R9 err one cycle", {31'b0, wr_err}, 32'd0);
    drain("R9 contents unchanged");
    rd("R9 nothing added");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule